// File: doc/BRIEF.md
# Data Bus Arbiter with Parking

This block decides which of the processor masters may drive a data bus that the masters share with a memory controller. A master has no explicit request line. A transfer-start strobe on the address bus counts as a request for a later data tenure, unless the transfer-type code on the same cycle marks the transfer as address-only. Requests wait in a small queue in address order. The arbiter hands out one grant per master and holds it for the whole data tenure, until the data-tenure-done input arrives.

A memory-side busy input blocks any new grant while the bus is taken by other traffic. When parking is enabled and no tenure is running, the bus is granted ahead of time to the master that most recently started an address transfer. That master can then begin its next data tenure without waiting for arbitration.

Top module: `dbus_data_arbiter`

## Requirements
- R1: After reset both grants are low, the request queue is empty and there is no park target. An idle cycle with parking enabled therefore leaves both grants low until some master starts an address transfer.
- R2: A start strobe on `addr_start[m]` whose type is not address-only queues a data request for master m. If the arbiter is idle, the queue was empty and the bus is not busy, `dbus_grant[m]` goes high after the clock edge that follows the edge sampling the strobe.
- R3: With the default mask decode, type codes 0, 4, 8, 12 and 16 are address-only and create no data request. With the list decode, exactly the codes in the list parameter are address-only.
- R4: At most one bit of `dbus_grant` is high in any cycle.
- R5: A grant given for a data tenure stays high and unchanged until `tenure_done` is sampled high, whatever `bus_busy` does.
- R6: Queued data requests are granted in the order of their start strobes, oldest first.
- R7: When `bus_busy` is sampled high and no tenure is running, both grants are low after that edge. Neither a queued request nor a park grant is given.
- R8: When `park_en` is high, no tenure is running, no request is queued and the bus is not busy, the grant goes to the master whose start strobe, of any type, was sampled most recently. A new strobe moves the park grant one edge later than the edge that samples it.
- R9: When `park_en` is low, no tenure is running and the queue is empty, both grants are low after the edge.
- R10: `tenure_done` sampled while no tenure is running has no effect on the grants.
- R11: When `tenure_done` ends a tenure, a request is queued and the bus is not busy, the next grant is given at that same edge, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| park_en | input | 1 | Enables parking of the idle bus on the last address owner |
| addr_start | input | N_MASTERS (2) | Per-master address transfer start strobe, at most one high |
| xfer_type | input | 5 | Transfer-type code of the current start strobe |
| bus_busy | input | 1 | Shared data bus is occupied by memory-side traffic |
| tenure_done | input | 1 | Current data tenure has ended |
| dbus_grant | output | N_MASTERS (2) | Per-master data bus grant |

## Verification
A queue pointer or count that is wrong makes the port show a grant to the wrong master, or an extra or missing grant, once the affected entry reaches the head. That happens within a few tenures. A wrong tenure flag shows up one edge later as a grant that drops without `tenure_done` or that survives it. A stale park target appears one edge after a start strobe as a park grant on the master that did not start. A decode fault shows two edges after a strobe, as a grant that should not be there or one that is missing.

// File: rtl/dba_pkg.sv
package dba_pkg;
   localparam int TT_W     = 5;
   localparam int TT_CODES = 1 << TT_W;

   typedef enum logic {
      DEC_MASK = 1'b0,
      DEC_LIST = 1'b1
   } dec_mode_e;
endpackage

// File: rtl/dba_type_decode.sv
module dba_type_decode #(
   parameter dba_pkg::dec_mode_e MODE = dba_pkg::DEC_MASK,
   parameter logic [dba_pkg::TT_CODES-1:0] ADDR_ONLY_MASK = 32'h0001_1111,
   parameter int LIST_N = 2,
   parameter logic [LIST_N*dba_pkg::TT_W-1:0] ADDR_ONLY_LIST = {5'd7, 5'd3}
) (
   input  logic [dba_pkg::TT_W-1:0] tt,
   output logic                     data_xfer
);
   localparam int W = dba_pkg::TT_W;

   if (LIST_N < 1) begin : g_bad_list
      $error("dba_type_decode: LIST_N must be at least 1");
   end

   if (MODE == dba_pkg::DEC_MASK) begin : g_mask
      // R3: one mask bit per code, set = address-only
      assign data_xfer = ~ADDR_ONLY_MASK[tt];
   end else begin : g_list
      logic [LIST_N-1:0] hit;
      for (genvar k = 0; k < LIST_N; k++) begin : g_cmp
         assign hit[k] = (tt == ADDR_ONLY_LIST[k*W +: W]);
      end
      assign data_xfer = ~|hit;
   end
endmodule

// File: rtl/dba_order_fifo.sv
module dba_order_fifo #(
   parameter int DEPTH = 4,
   parameter int ID_W  = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  logic [ID_W-1:0] push_id,
   input  logic            pop,
   output logic            empty,
   output logic [ID_W-1:0] head
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("dba_order_fifo: DEPTH must be at least 2");
   end

   logic [ID_W-1:0]  slot_q [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [CNT_W-1:0] cnt_q;
   logic             full, do_push, do_pop;

   function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign head    = slot_q[rd_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wr_q <= ptr_inc(wr_q);
         if (do_pop)  rd_q <= ptr_inc(rd_q);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) slot_q[wr_q] <= push_id;
   end

   // R6: the order queue never loses a request
   p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));
   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/dba_owner_track.sv
module dba_owner_track #(
   parameter int ID_W = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_any,
   input  logic [ID_W-1:0] start_id,
   output logic            owner_valid,
   output logic [ID_W-1:0] owner_id
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_valid <= 1'b0;
         owner_id    <= '0;
      end else if (start_any) begin
         owner_valid <= 1'b1;
         owner_id    <= start_id;
      end
   end

   // R8: the park target follows the latest start of any type
   p_owner_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_any |=> (owner_valid && owner_id == $past(start_id)));
endmodule

// File: rtl/dba_grant_ctrl.sv
module dba_grant_ctrl #(
   parameter int N_MASTERS = 2,
   parameter int ID_W      = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 park_en,
   input  logic                 bus_busy,
   input  logic                 tenure_done,
   input  logic                 q_valid,
   input  logic [ID_W-1:0]      q_head,
   input  logic                 park_valid,
   input  logic [ID_W-1:0]      park_id,
   output logic                 pop,
   output logic [N_MASTERS-1:0] grant
);
   logic                 active_q, active_d;
   logic [ID_W-1:0]      owner_q, owner_d;
   logic [N_MASTERS-1:0] grant_q, grant_d;

   always_comb begin
      active_d = active_q;
      owner_d  = owner_q;
      pop      = 1'b0;
      if (!active_q || tenure_done) begin
         active_d = 1'b0;
         if (q_valid && !bus_busy) begin
            active_d = 1'b1;
            owner_d  = q_head;
            pop      = 1'b1;
         end
      end
      grant_d = '0;
      for (int i = 0; i < N_MASTERS; i++) begin
         if (active_d) begin
            grant_d[i] = (owner_d == ID_W'(i));
         end else if (park_en && !bus_busy && park_valid) begin
            grant_d[i] = (park_id == ID_W'(i));
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         owner_q  <= '0;
         grant_q  <= '0;
      end else begin
         active_q <= active_d;
         owner_q  <= owner_d;
         grant_q  <= grant_d;
      end
   end

   assign grant = grant_q;

   p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_q));
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !tenure_done) |=> $stable(grant_q));
   p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_busy && !active_q) |=> (grant_q == '0));
   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!park_en && !active_q && !q_valid) |=> (grant_q == '0));
   p_handover_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && tenure_done && q_valid && !bus_busy) |=> (grant_q != '0));
endmodule

// File: rtl/dbus_data_arbiter.sv
module dbus_data_arbiter #(
   parameter int N_MASTERS = 2,
   parameter int Q_DEPTH   = 4,
   parameter dba_pkg::dec_mode_e DECODE_MODE = dba_pkg::DEC_MASK,
   parameter logic [dba_pkg::TT_CODES-1:0] ADDR_ONLY_MASK = 32'h0001_1111,
   parameter int LIST_N = 2,
   parameter logic [LIST_N*dba_pkg::TT_W-1:0] ADDR_ONLY_LIST = {5'd7, 5'd3}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     park_en,
   input  logic [N_MASTERS-1:0]     addr_start,
   input  logic [dba_pkg::TT_W-1:0] xfer_type,
   input  logic                     bus_busy,
   input  logic                     tenure_done,
   output logic [N_MASTERS-1:0]     dbus_grant
);
   localparam int ID_W = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1;

   if (N_MASTERS < 2) begin : g_bad_masters
      $error("dbus_data_arbiter: N_MASTERS must be at least 2");
   end

   logic            start_any, data_xfer, data_req, pop, q_empty;
   logic [ID_W-1:0] start_id, q_head, park_id;
   logic            park_valid;

   always_comb begin
      start_id = '0;
      for (int i = 0; i < N_MASTERS; i++) begin
         if (addr_start[i]) start_id = ID_W'(i);
      end
   end

   assign start_any = |addr_start;
   assign data_req  = start_any && data_xfer;

   dba_type_decode #(
      .MODE(DECODE_MODE), .ADDR_ONLY_MASK(ADDR_ONLY_MASK),
      .LIST_N(LIST_N), .ADDR_ONLY_LIST(ADDR_ONLY_LIST)
   ) u_dec (
      .tt(xfer_type), .data_xfer(data_xfer)
   );

   dba_order_fifo #(.DEPTH(Q_DEPTH), .ID_W(ID_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(data_req), .push_id(start_id),
      .pop(pop), .empty(q_empty), .head(q_head)
   );

   dba_owner_track #(.ID_W(ID_W)) u_owner (
      .clk(clk), .rst_n(rst_n), .start_any(start_any), .start_id(start_id),
      .owner_valid(park_valid), .owner_id(park_id)
   );

   dba_grant_ctrl #(.N_MASTERS(N_MASTERS), .ID_W(ID_W)) u_grant (
      .clk(clk), .rst_n(rst_n), .park_en(park_en), .bus_busy(bus_busy),
      .tenure_done(tenure_done), .q_valid(!q_empty), .q_head(q_head),
      .park_valid(park_valid), .park_id(park_id), .pop(pop),
      .grant(dbus_grant)
   );

   // R8: the shared address bus carries one start at a time
   p_one_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(addr_start));
endmodule

// File: tb/sim_dbus_data_arbiter.sv
module sim_dbus_data_arbiter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       park_en = 1'b0;
   logic [1:0] addr_start = '0;
   logic [1:0] s1_start = '0;
   logic [4:0] xfer_type = '0;
   logic       bus_busy = 1'b0;
   logic       tenure_done = 1'b0;
   logic [1:0] dbus_grant, grant_l;
   int         checks = 0;
   int         errors = 0;
   bit         finished = 1'b0;

   always #2 clk = ~clk;

   dbus_data_arbiter u0 (
      .clk(clk), .rst_n(rst_n), .park_en(park_en), .addr_start(addr_start),
      .xfer_type(xfer_type), .bus_busy(bus_busy), .tenure_done(tenure_done),
      .dbus_grant(dbus_grant)
   );

   // list-decode variant: codes 3 and 7 are address-only
   dbus_data_arbiter #(.DECODE_MODE(dba_pkg::DEC_LIST)) u1 (
      .clk(clk), .rst_n(rst_n), .park_en(park_en), .addr_start(s1_start),
      .xfer_type(xfer_type), .bus_busy(bus_busy), .tenure_done(tenure_done),
      .dbus_grant(grant_l)
   );

   // {start[1:0], type[4:0], busy, done, park, expected grant[1:0]}
   localparam int NV = 25;
   localparam logic [11:0] VEC [NV] = '{
      {2'b00, 5'd0, 1'b0, 1'b0, 1'b1, 2'b00},
      {2'b10, 5'd2, 1'b0, 1'b0, 1'b0, 2'b00},
      {2'b00, 5'd0, 1'b0, 1'b0, 1'b0, 2'b10},
      {2'b01, 5'd2, 1'b0, 1'b0, 1'b0, 2'b10},
      {2'b00, 5'd0, 1'b0, 1'b0, 1'b0, 2'b10},
      {2'b00, 5'd0, 1'b0, 1'b1, 1'b0, 2'b01},
      {2'b10, 5'd4, 1'b0, 1'b0, 1'b0, 2'b01},
      {2'b00, 5'd0, 1'b0, 1'b1, 1'b0, 2'b00},
      {2'b00, 5'd0, 1'b0, 1'b0, 1'b1, 2'b10},
      {2'b00, 5'd0, 1'b1, 1'b0, 1'b1, 2'b00},
      {2'b00, 5'd0, 1'b0, 1'b0, 1'b1, 2'b10},
      {2'b01, 5'd8, 1'b0, 1'b0, 1'b1, 2'b10},
      {2'b00, 5'd0, 1'b0, 1'b0, 1'b1, 2'b01},
      {2'b10, 5'd2, 1'b1, 1'b0, 1'b1, 2'b00},
      {2'b00, 5'd0, 1'b1, 1'b0, 1'b1, 2'b00},
      {2'b00, 5'd0, 1'b0, 1'b0, 1'b1, 2'b10},
      {2'b01, 5'd2, 1'b0, 1'b1, 1'b0, 2'b00},
      {2'b00, 5'd0, 1'b0, 1'b0, 1'b0, 2'b01},
      {2'b00, 5'd0, 1'b1, 1'b1, 1'b1, 2'b00},
      {2'b00, 5'd0, 1'b0, 1'b1, 1'b1, 2'b01},
      {2'b00, 5'd0, 1'b0, 1'b0, 1'b0, 2'b00},
      {2'b10, 5'd2, 1'b0, 1'b0, 1'b0, 2'b00},
      {2'b00, 5'd0, 1'b0, 1'b0, 1'b0, 2'b10},
      {2'b00, 5'd0, 1'b1, 1'b0, 1'b0, 2'b10},
      {2'b00, 5'd0, 1'b0, 1'b1, 1'b0, 2'b00}
   };

   function automatic string row_req(input int r);
      case (r)
         0:                      return "R1";
         1, 2, 15, 17, 21, 22:   return "R2";
         3, 4, 23:               return "R5";
         5:                      return "R11";
         6:                      return "R3";
         8, 10, 11, 12:          return "R8";
         9, 13, 14, 18:          return "R7";
         19:                     return "R10";
         default:                return "R9";
      endcase
   endfunction

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: grant=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic [1:0] st, input logic [4:0] tt,
                      input logic busy, input logic done, input logic pk);
      @(negedge clk);
      addr_start  = st;
      xfer_type   = tt;
      bus_busy    = busy;
      tenure_done = done;
      park_en     = pk;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1", dbus_grant, 2'b00);
      @(negedge clk);
      rst_n = 1'b1;

      for (int r = 0; r < NV; r++) begin
         cyc(VEC[r][11:10], VEC[r][9:5], VEC[r][4], VEC[r][3], VEC[r][2]);
         chk(row_req(r), dbus_grant, VEC[r][1:0]);
         chk("R4", {1'b0, dbus_grant[1] & dbus_grant[0]}, 2'b00);
      end

      // R6: three requests queued behind a tenure, served oldest first
      cyc(2'b01, 5'd2, 1'b0, 1'b0, 1'b0);
      chk("R6", dbus_grant, 2'b00);
      cyc(2'b10, 5'd2, 1'b0, 1'b0, 1'b0);
      chk("R6", dbus_grant, 2'b01);
      cyc(2'b01, 5'd2, 1'b0, 1'b0, 1'b0);
      chk("R6", dbus_grant, 2'b01);
      cyc(2'b00, 5'd0, 1'b0, 1'b0, 1'b0);
      chk("R5", dbus_grant, 2'b01);
      cyc(2'b00, 5'd0, 1'b0, 1'b1, 1'b0);
      chk("R6", dbus_grant, 2'b10);
      cyc(2'b00, 5'd0, 1'b0, 1'b1, 1'b0);
      chk("R6", dbus_grant, 2'b01);
      cyc(2'b00, 5'd0, 1'b0, 1'b1, 1'b0);
      chk("R9", dbus_grant, 2'b00);

      // R1: reset in the middle of a tenure clears grant and park target
      cyc(2'b10, 5'd2, 1'b0, 1'b0, 1'b0);
      cyc(2'b00, 5'd0, 1'b0, 1'b0, 1'b0);
      chk("R2", dbus_grant, 2'b10);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", dbus_grant, 2'b00);
      @(negedge clk);
      rst_n = 1'b1;
      cyc(2'b00, 5'd0, 1'b0, 1'b0, 1'b1);
      chk("R1", dbus_grant, 2'b00);
      cyc(2'b00, 5'd0, 1'b0, 1'b0, 1'b1);
      chk("R1", dbus_grant, 2'b00);

      // R3: list decode instance, code 3 address-only, code 4 a data transfer
      @(negedge clk);
      s1_start = 2'b01;
      xfer_type = 5'd3;
      park_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      s1_start = 2'b00;
      @(posedge clk);
      #1;
      chk("R3", grant_l, 2'b00);
      @(negedge clk);
      s1_start = 2'b01;
      xfer_type = 5'd4;
      @(posedge clk);
      #1;
      chk("R3", grant_l, 2'b00);
      @(negedge clk);
      s1_start = 2'b00;
      @(posedge clk);
      #1;
      chk("R3", grant_l, 2'b01);
      cyc(2'b00, 5'd0, 1'b0, 1'b1, 1'b0);
      chk("R9", grant_l, 2'b00);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule